// File: doc/BRIEF.md
# Single-Precision Multiply Exception-Flag Unit

This block takes two IEEE-754 single-precision operands and a rounding mode. It works out which exceptions multiplying them would raise, and returns those exceptions as a 32-bit integer vector. The product itself is never returned. Operands whose exponent field is zero and whose fraction is non-zero are flushed to zero before the multiply, and a dedicated bit reports this. A second dedicated bit reports a product that would land in the denormal range.

The unit is a three-stage pipeline that accepts one operation per cycle. Stage one classifies the operands and forms the 48-bit significand product. Stage two normalises and rounds that product, or selects the special-case result. Stage three drives the outputs. Each operation can carry a guard bit. A valid strobe and a write-enable travel beside the flags, so that a register file downstream writes only when the operation is unguarded or its guard bit is 1.

Top module: `fmf_mul_flags`

## Requirements
- R1: The output word has these fixed bit positions: bit 0 divide-by-zero (always 0 for a multiply), bit 1 inexact, bit 2 underflow, bit 3 overflow, bit 4 invalid, bit 5 input flushed, bit 6 output in denormal range. Bits 31:7 are always 0.
- R2: `out_valid` rises exactly 3 clock edges after the edge that samples `in_valid`=1. Back-to-back operations come out in issue order, one per cycle.
- R3: `out_wen` equals the issuing operation's `in_valid & (!in_guarded | in_guard_bit)`, delayed by the same 3 edges.
- R4: An operand with exponent field 0 and a non-zero fraction is treated as zero and sets bit 5. For example, 0x40400000 times 0x00400000 gives 0x20.
- R5: A NaN operand (exponent 255, fraction non-zero) sets invalid when its fraction bit 22 is 0 (signalling), and raises nothing when bit 22 is 1. Infinity times zero, in either order and including a flushed zero, gives invalid only. Infinity times infinity or times a non-zero finite value gives 0.
- R6: When the rounded product's biased exponent is 255 or above, the result has overflow and inexact set (0x0a).
- R7: When the normalised exact product's biased exponent is 0 or below, underflow and inexact are set. Bit 6 is added when that biased exponent is -22 or above, which means the value lies between 2^-149 and 2^-126. So 0.5 times 0x00800000 gives 0x46, and 0x00800000 squared gives 0x06.
- R8: For a product in the normal range, inexact is set exactly when any discarded significand bit is 1. Exact products such as 3.0 times -3.0 give 0.
- R9: Rounding-mode input encoding: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf. A round-up that carries out of the significand at biased exponent 254 turns the result into overflow, so 0x7F3504F3 times 0x3FB504F3 gives 0x0a under mode 10 and 0x02 under mode 01 or 11.
- R10: Zero times a finite value raises no flags.
- R11: While reset is asserted, and on the first cycle after it, `out_valid` and `out_wen` are 0 and the flag word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_op_a | input | 32 | First single-precision operand |
| in_op_b | input | 32 | Second single-precision operand |
| in_rmode | input | 2 | Rounding mode (R9 encoding) |
| in_guarded | input | 1 | Operation carries a guard |
| in_guard_bit | input | 1 | Least significant bit of the guard value |
| out_valid | output | 1 | Result present |
| out_wen | output | 1 | Destination should be written |
| out_flags | output | 32 | Exception vector (R1 layout) |

## Verification
A cross-product sweep pairs exponents at the boundaries (0, 1, 2, the denormal-range floor around 104 and 105, 126 to 128, 253 to 255) with fractions that are zero, one ulp, the quiet bit alone, all ones, and a value near the square root of two. Each pair runs under every rounding mode. This separates flushing, special cases, the tiny and denormal-range limits, and overflow. Directed pairs built so that the rounded significand is all ones at exponent 254 show that the rounding mode alone can decide overflow. Random operands with random guards stress back-to-back issue and the write-enable path. Every result is compared with an integer reference that locates the product's leading one and rounds by comparing the remainder against half an ulp.

// File: rtl/fmf_pkg.sv
package fmf_pkg;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int MANT_W    = FRAC_W + 1;
  localparam int PROD_W    = 2 * MANT_W;
  localparam int WORD_W    = 1 + EXP_W + FRAC_W;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP   = (1 << EXP_W) - 1;
  localparam int SEXP_W    = EXP_W + 3;
  localparam int OFZ_FLOOR = -(FRAC_W - 1);
  localparam int NFLAG     = 7;

  // flag bit positions (decoded by the consumer of the vector)
  localparam int FLG_DBZ = 0;
  localparam int FLG_INX = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_OVF = 3;
  localparam int FLG_INV = 4;
  localparam int FLG_IFZ = 5;
  localparam int FLG_OFZ = 6;

  typedef logic [NFLAG-1:0] flags_t;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } sp_t;

  typedef enum logic [1:0] {
    RM_NE = 2'b00,
    RM_RZ = 2'b01,
    RM_UP = 2'b10,
    RM_DN = 2'b11
  } rmode_e;

  function automatic logic is_denorm(sp_t x);
    return (x.exp == '0) && (x.frac != '0);
  endfunction

  function automatic logic is_inf(sp_t x);
    return (x.exp == '1) && (x.frac == '0);
  endfunction

  function automatic logic is_nan(sp_t x);
    return (x.exp == '1) && (x.frac != '0);
  endfunction

  function automatic logic is_snan(sp_t x);
    return is_nan(x) && !x.frac[FRAC_W-1];
  endfunction

  // increment decision for a truncated magnitude
  function automatic logic rnd_incr(rmode_e rm, logic sgn, logic lsb,
                                    logic gbit, logic sticky);
    logic r;
    case (rm)
      RM_NE:   r = gbit & (sticky | lsb);
      RM_RZ:   r = 1'b0;
      RM_UP:   r = (gbit | sticky) & ~sgn;
      default: r = (gbit | sticky) & sgn;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fmf_unpack.sv
module fmf_unpack
  import fmf_pkg::*;
(
  input  sp_t                        op_a,
  input  sp_t                        op_b,
  output logic                       special,
  output flags_t                     spec_flags,
  output logic                       flush_in,
  output logic [PROD_W-1:0]          mant_prod,
  output logic signed [SEXP_W-1:0]   exp_sum,
  output logic                       prod_sign
);
  localparam logic signed [SEXP_W-1:0] BIAS_S = SEXP_W'(BIAS);

  logic den_a, den_b, zer_a, zer_b, inf_a, inf_b, nan_a, nan_b, sn_a, sn_b;
  logic [MANT_W-1:0] man_a, man_b;
  logic signed [SEXP_W-1:0] ea_s, eb_s;

  assign den_a = is_denorm(op_a);
  assign den_b = is_denorm(op_b);
  assign zer_a = (op_a.exp == '0);
  assign zer_b = (op_b.exp == '0);
  assign inf_a = is_inf(op_a);
  assign inf_b = is_inf(op_b);
  assign nan_a = is_nan(op_a);
  assign nan_b = is_nan(op_b);
  assign sn_a  = is_snan(op_a);
  assign sn_b  = is_snan(op_b);

  assign flush_in  = den_a | den_b;
  assign prod_sign = op_a.sign ^ op_b.sign;

  assign man_a     = {1'b1, op_a.frac};
  assign man_b     = {1'b1, op_b.frac};
  assign mant_prod = {{MANT_W{1'b0}}, man_a} * {{MANT_W{1'b0}}, man_b};

  assign ea_s    = $signed({{(SEXP_W-EXP_W){1'b0}}, op_a.exp});
  assign eb_s    = $signed({{(SEXP_W-EXP_W){1'b0}}, op_b.exp});
  assign exp_sum = ea_s + eb_s - BIAS_S;

  always_comb begin
    special    = 1'b1;
    spec_flags = '0;
    if (nan_a | nan_b) begin
      spec_flags[FLG_INV] = sn_a | sn_b;
    end else if ((inf_a & zer_b) | (zer_a & inf_b)) begin
      spec_flags[FLG_INV] = 1'b1;
    end else if (inf_a | inf_b | zer_a | zer_b) begin
      spec_flags = '0;
    end else begin
      special = 1'b0;
    end
  end
endmodule

// File: rtl/fmf_round.sv
module fmf_round
  import fmf_pkg::*;
(
  input  logic [PROD_W-1:0]         prod,
  input  logic signed [SEXP_W-1:0]  exp_sum,
  input  logic                      sgn,
  input  rmode_e                    rm,
  output flags_t                    flags,
  output logic                      ev_tiny,
  output logic                      ev_ovf,
  output logic                      ev_dnrange,
  output logic                      ev_carry
);
  localparam logic signed [SEXP_W-1:0] ZERO_S  = '0;
  localparam logic signed [SEXP_W-1:0] TOP_S   = SEXP_W'(EXP_TOP);
  localparam logic signed [SEXP_W-1:0] FLOOR_S = SEXP_W'(OFZ_FLOOR);

  logic              hi;
  logic [MANT_W-1:0] mant;
  logic              gbit, sticky, incr;
  logic signed [SEXP_W-1:0] e_norm, e_rnd;

  assign hi     = prod[PROD_W-1];
  assign mant   = hi ? prod[PROD_W-1 -: MANT_W] : prod[PROD_W-2 -: MANT_W];
  assign gbit   = hi ? prod[PROD_W-1-MANT_W] : prod[PROD_W-2-MANT_W];
  assign sticky = hi ? (|prod[PROD_W-2-MANT_W:0]) : (|prod[PROD_W-3-MANT_W:0]);

  assign e_norm   = exp_sum + $signed({{(SEXP_W-1){1'b0}}, hi});
  assign incr     = rnd_incr(rm, sgn, mant[0], gbit, sticky);
  assign ev_carry = incr & (&mant);
  assign e_rnd    = e_norm + $signed({{(SEXP_W-1){1'b0}}, ev_carry});

  assign ev_tiny    = (e_norm <= ZERO_S);
  assign ev_dnrange = ev_tiny && (e_norm >= FLOOR_S);
  assign ev_ovf     = !ev_tiny && (e_rnd >= TOP_S);

  always_comb begin
    flags = '0;
    if (ev_tiny) begin
      flags[FLG_UNF] = 1'b1;
      flags[FLG_INX] = 1'b1;
      flags[FLG_OFZ] = ev_dnrange;
    end else if (ev_ovf) begin
      flags[FLG_OVF] = 1'b1;
      flags[FLG_INX] = 1'b1;
    end else begin
      flags[FLG_INX] = gbit | sticky;
    end
  end
endmodule

// File: rtl/fmf_mul_flags.sv
module fmf_mul_flags
  import fmf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_op_a,
  input  logic [31:0] in_op_b,
  input  logic [1:0]  in_rmode,
  input  logic        in_guarded,
  input  logic        in_guard_bit,
  output logic        out_valid,
  output logic        out_wen,
  output logic [31:0] out_flags
);
  sp_t a_w, b_w;
  assign a_w = in_op_a;
  assign b_w = in_op_b;

  // stage 0: classify and multiply
  logic                      c_special, c_flush, c_sign;
  flags_t                    c_spec_flags;
  logic [PROD_W-1:0]         c_prod;
  logic signed [SEXP_W-1:0]  c_exp;
  logic                      c_wen;

  assign c_wen = in_valid & (~in_guarded | in_guard_bit);

  fmf_unpack u_unpack (
    .op_a      (a_w),
    .op_b      (b_w),
    .special   (c_special),
    .spec_flags(c_spec_flags),
    .flush_in  (c_flush),
    .mant_prod (c_prod),
    .exp_sum   (c_exp),
    .prod_sign (c_sign)
  );

  // stage 1 registers
  logic                      s1_valid, s1_wen, s1_special, s1_flush, s1_sign;
  flags_t                    s1_spec_flags;
  logic [PROD_W-1:0]         s1_prod;
  logic signed [SEXP_W-1:0]  s1_exp;
  rmode_e                    s1_rm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wen   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_wen   <= c_wen;
    end
  end

  always_ff @(posedge clk) begin
    s1_special    <= c_special;
    s1_spec_flags <= c_spec_flags;
    s1_flush      <= c_flush;
    s1_sign       <= c_sign;
    s1_prod       <= c_prod;
    s1_exp        <= c_exp;
    s1_rm         <= rmode_e'(in_rmode);
  end

  // normalise and round
  flags_t arith_flags, merged_flags;
  logic   ev_tiny, ev_ovf, ev_dnrange, ev_carry;

  fmf_round u_round (
    .prod      (s1_prod),
    .exp_sum   (s1_exp),
    .sgn       (s1_sign),
    .rm        (s1_rm),
    .flags     (arith_flags),
    .ev_tiny   (ev_tiny),
    .ev_ovf    (ev_ovf),
    .ev_dnrange(ev_dnrange),
    .ev_carry  (ev_carry)
  );

  always_comb begin
    merged_flags          = s1_special ? s1_spec_flags : arith_flags;
    merged_flags[FLG_IFZ] = s1_flush;
  end

  // stage 2 and output registers
  logic   s2_valid, s2_wen;
  flags_t s2_flags, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_wen    <= 1'b0;
      s2_flags  <= '0;
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
      out_q     <= '0;
    end else begin
      s2_valid  <= s1_valid;
      s2_wen    <= s1_wen;
      s2_flags  <= merged_flags;
      out_valid <= s2_valid;
      out_wen   <= s2_wen;
      out_q     <= s2_flags;
    end
  end

  assign out_flags = {{(WORD_W-NFLAG){1'b0}}, out_q};

  // ---------------- assertions ----------------
  logic [1:0] rs_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rs_age <= 2'd0;
    else if (rs_age != 2'd3) rs_age <= rs_age + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3
  wen_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_age == 2'd3) |-> (out_wen == $past(in_valid & (~in_guarded | in_guard_bit), 3)));

  // R3
  wen_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_valid);

  // R1
  dbz_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_q[FLG_DBZ]);

  // R5
  inv_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_q[FLG_INV]) |-> (out_q[FLG_OVF:FLG_INX] == '0));

  // R6
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_q[FLG_OVF]) |-> (out_q[FLG_INX] && !out_q[FLG_UNF]));

  // R7
  ofz_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_q[FLG_OFZ]) |-> (out_q[FLG_UNF] && out_q[FLG_INX]));

  // R9
  carry_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_special && ev_carry && !ev_tiny && (s1_exp + $signed({{(SEXP_W-1){1'b0}}, s1_prod[PROD_W-1]}) == SEXP_W'(EXP_TOP - 1)))
      |=> s2_flags[FLG_OVF]);
endmodule

// File: tb/fmf_mul_flags_tb_top.sv
`timescale 1ns/1ps
module fmf_mul_flags_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_op_a = '0, in_op_b = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_guarded = 1'b0, in_guard_bit = 1'b0;
  logic        out_valid, out_wen;
  logic [31:0] out_flags;

  always #2.5 clk = ~clk;

  fmf_mul_flags dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op_a(in_op_a),
    .in_op_b(in_op_b), .in_rmode(in_rmode), .in_guarded(in_guarded),
    .in_guard_bit(in_guard_bit), .out_valid(out_valid), .out_wen(out_wen),
    .out_flags(out_flags)
  );

  int checks = 0;
  int bad = 0;
  bit done = 0;
  bit vh [3];
  logic [31:0] q_flags [$];
  bit          q_wen [$];
  string       q_tag [$];

  // independent reference: leading-one search and half-ulp comparison
  function automatic logic [31:0] ref_flags(logic [31:0] a, logic [31:0] b,
                                            logic [1:0] rm, output string tag);
    logic [31:0] res;
    int ea, eb, e, msb, sh;
    logic [22:0] fa, fb;
    bit ifz, za, zb, ia, ib, na, nb, sa, sb, sgn, up;
    logic [63:0] p, keep, rem, half;
    res = 0; ifz = 0; up = 0;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = a[22:0]; fb = b[22:0];
    if (ea == 0 && fa != 0) begin ifz = 1; fa = 0; end
    if (eb == 0 && fb != 0) begin ifz = 1; fb = 0; end
    za = (ea == 0); zb = (eb == 0);
    ia = (ea == 255 && fa == 0); ib = (eb == 255 && fb == 0);
    na = (ea == 255 && fa != 0); nb = (eb == 255 && fb != 0);
    sa = na && !fa[22]; sb = nb && !fb[22];
    tag = "R10";
    if (na || nb) begin res[4] = sa | sb; tag = "R5"; end
    else if ((ia && zb) || (za && ib)) begin res[4] = 1; tag = "R5"; end
    else if (ia || ib) tag = "R5";
    else if (za || zb) tag = "R10";
    else begin
      p = 64'({1'b1, fa}) * 64'({1'b1, fb});
      msb = p[47] ? 47 : 46;
      sh = msb - 23;
      keep = p >> sh;
      rem = p - (keep << sh);
      half = 64'd1 << (sh - 1);
      sgn = a[31] ^ b[31];
      e = ea + eb - 127 + (msb - 46);
      case (rm)
        2'd0: up = (rem > half) || (rem == half && keep[0]);
        2'd1: up = 0;
        2'd2: up = (rem != 0) && !sgn;
        default: up = (rem != 0) && sgn;
      endcase
      if (e < 1) begin
        res[2] = 1; res[1] = 1;
        if (e > -23) res[6] = 1;
        tag = "R7";
      end else begin
        if (keep + 64'(up) == 64'd1 << 24) e = e + 1;
        if (e > 254) begin res[3] = 1; res[1] = 1; tag = "R6"; end
        else begin res[1] = (rem != 0); tag = "R8"; end
      end
    end
    res[5] = ifz;
    if (ifz) tag = "R4";
    return res;
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== vh[2]) begin
      bad++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, vh[2]);
    end
    if (vh[2] && q_flags.size() > 0) begin
      logic [31:0] ef;
      bit ew;
      string tg;
      ef = q_flags.pop_front(); ew = q_wen.pop_front(); tg = q_tag.pop_front();
      checks++;
      if (out_flags !== ef) begin
        bad++;
        $display("FAIL %s (R1 layout) flags actual=%08h expected=%08h", tg, out_flags, ef);
      end
      checks++;
      if (out_wen !== ew) begin
        bad++;
        $display("FAIL R3 wen actual=%0b expected=%0b", out_wen, ew);
      end
    end
  endtask

  task automatic step(bit v, logic [31:0] a, logic [31:0] b, logic [1:0] rm,
                      bit gd, bit gb, bit use_ref, logic [31:0] ef, string tg);
    string rt;
    logic [31:0] rf;
    @(negedge clk);
    check_out();
    vh[2] = vh[1]; vh[1] = vh[0]; vh[0] = v;
    in_valid = v; in_op_a = a; in_op_b = b; in_rmode = rm;
    in_guarded = gd; in_guard_bit = gb;
    if (v) begin
      rf = ref_flags(a, b, rm, rt);
      if (use_ref) begin q_flags.push_back(rf); q_tag.push_back(rt); end
      else begin q_flags.push_back(ef); q_tag.push_back(tg); end
      q_wen.push_back(!gd || gb);
    end
  endtask

  task automatic op(logic [31:0] a, logic [31:0] b, logic [1:0] rm, logic [31:0] ef, string tg);
    step(1, a, b, rm, 0, 0, 0, ef, tg);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, 0, "R2");
  endtask

  function automatic logic [31:0] mk(int s, int e, logic [22:0] f);
    return {s[0], e[7:0], f};
  endfunction

  initial begin
    int exps [13] = '{0, 1, 2, 63, 104, 105, 126, 127, 128, 200, 253, 254, 255};
    logic [22:0] fracs [5] = '{23'h0, 23'h1, 23'h400000, 23'h7fffff, 23'h3504f3};
    repeat (4) @(negedge clk);
    // R11 reset state
    checks++;
    if (out_valid !== 0 || out_wen !== 0 || out_flags !== 0) begin
      bad++;
      $display("FAIL R11 reset actual=%0b/%0b/%08h expected=0/0/00000000", out_valid, out_wen, out_flags);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_flags !== 0) begin
      bad++;
      $display("FAIL R11 after release actual=%0b/%08h expected=0/00000000", out_valid, out_flags);
    end

    // directed values
    op(32'hc0400000, 32'h3f800000, 0, 32'h00, "R8");
    op(32'h40400000, 32'hc0400000, 0, 32'h00, "R8");
    op(32'h3f000000, 32'h00800000, 0, 32'h46, "R7");
    op(32'h7f800000, 32'h00000000, 0, 32'h10, "R5");
    op(32'h40400000, 32'h00400000, 0, 32'h20, "R4");
    op(32'h00c00000, 32'h80800000, 0, 32'h06, "R7");
    op(32'h7f800000, 32'hff800000, 0, 32'h00, "R5");
    op(32'h7f7fffff, 32'h7f7fffff, 0, 32'h0a, "R6");
    op(32'h00800000, 32'h00800000, 0, 32'h06, "R7");
    op(32'h7f800001, 32'h3f800000, 0, 32'h10, "R5");
    op(32'h7fc00000, 32'h3f800000, 0, 32'h00, "R5");
    op(32'h00000000, 32'h40400000, 0, 32'h00, "R10");
    op(32'h00400000, 32'h7f800000, 0, 32'h30, "R5");
    op(32'h7F3504F3, 32'h3FB504F3, 2'b10, 32'h0a, "R9");
    op(32'h7F3504F3, 32'h3FB504F3, 2'b01, 32'h02, "R9");
    op(32'h7F3504F3, 32'h3FB504F3, 2'b11, 32'h02, "R9");
    op(32'hFF3504F3, 32'h3FB504F3, 2'b11, 32'h0a, "R9");
    op(32'hFF3504F3, 32'h3FB504F3, 2'b10, 32'h02, "R9");
    // R3 guard variants
    step(1, 32'h40400000, 32'h00800000, 0, 1, 0, 0, 32'h00, "R3");
    step(1, 32'h40400000, 32'h00800000, 0, 1, 1, 0, 32'h00, "R3");
    idle(5);

    // sweep over boundary exponents and fractions, every rounding mode
    for (int i = 0; i < 65; i++)
      for (int j = 0; j < 65; j++)
        for (int r = 0; r < 4; r++)
          step(1, mk(i, exps[i/5], fracs[i%5]), mk(j + r, exps[j/5], fracs[j%5]),
               r[1:0], bit'(j[0]), bit'(i[1]), 1, 0, "");
    idle(4);

    // random back-to-back with gaps and guards
    for (int k = 0; k < 20000; k++) begin
      logic [31:0] ra, rb, rr;
      ra = $urandom; rb = $urandom; rr = $urandom;
      if (rr[4]) rb[30:23] = 8'(254 - int'(ra[30:23]) + int'(rr[7:5]));
      step(rr[8:6] != 0, ra, rb, rr[1:0], rr[2], rr[3], 1, 0, "");
    end
    idle(6);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule